// File: doc/BRIEF.md
# Converter Reset and Calibration Sequencer

This block runs on the host side of a self-calibrating pipelined 16-bit converter. It drives the converter's reset, calibrate and active-low power-down controls, along with the enable for the forwarded conversion clock. Every control is updated on the rising edge of that conversion clock.

When the host raises `pwr_on`, the sequencer first waits a settle period so the converter's references can stabilise. It then drives a reset pulse, followed at once by a calibrate pulse. Next it counts out the calibration time and a blanking window as long as the pipeline latency. Only after that does it raise `data_valid`.

A one-cycle `recal_req` pulse starts a new calibration. In the ready state it takes effect at once. While a sequence is running it is remembered and served when the sequence ends. Dropping `pwr_on` forces power-down from any state. Leaving power-down always repeats the settle, reset and calibration steps.

Top module: `conv_cal_sequencer`

## Requirements
- R1: While `rst_n` is low, and in power-down, `adc_pd_n`, `clk_en`, `adc_rst`, `adc_cal`, `data_valid` and `busy` are all 0.
- R2: After `pwr_on` is sampled high in power-down, the next SETTLE_CYC cycles show `adc_pd_n`=1, `clk_en`=1, `busy`=1, with `adc_rst`, `adc_cal` and `data_valid` at 0.
- R3: `adc_rst` is then high for exactly PULSE_CYC cycles. `adc_cal` follows immediately for exactly PULSE_CYC cycles. The two are never high together, and calibrate never rises without a reset in the cycle before it.
- R4: After `adc_cal` falls, `data_valid` stays 0 and `busy` stays 1 for CAL_CYC+BLANK_CYC cycles, with no reset or calibrate asserted.
- R5: `data_valid` is 1 only in the ready state, and there `busy` is 0.
- R6: A `recal_req` sampled in the ready state starts a reset pulse in the next cycle, with no settle wait.
- R7: A `recal_req` sampled while `busy` is 1 is held pending. The following ready state then lasts exactly one cycle before a new reset pulse begins.
- R8: `pwr_on` sampled low forces power-down in the next cycle from any state. A pending request is discarded, and `recal_req` has no effect in power-down.
- R9: `clk_en` is 1 in every state other than power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous host reset |
| pwr_on | input | 1 | Host wants the converter active (low = power-down) |
| recal_req | input | 1 | One-cycle request for a new calibration |
| adc_rst | output | 1 | Converter reset control |
| adc_cal | output | 1 | Converter calibrate control |
| adc_pd_n | output | 1 | Converter power-down control, active low |
| clk_en | output | 1 | Enable for the forwarded conversion clock |
| data_valid | output | 1 | Converter output data can be trusted |
| busy | output | 1 | Settle, reset, calibrate or blanking in progress |

## Verification
The hardest situation to reach is a power-down that lands in the middle of a sequence while a recalibration request is pending. That pending request must vanish, so after power-up the ready state must hold instead of restarting. The stimulus first drives a random `recal_req` inside a sequence and then drops `pwr_on` at a later random cycle. After re-enabling power, it checks that the ready state lasts several cycles. Other runs place the request at random points of the busy window and check that ready lasts exactly one cycle.

// File: rtl/conv_cal_sequencer.sv
module conv_cal_sequencer #(
  parameter int PULSE_CYC  = 2,
  parameter int SETTLE_CYC = 250000,
  parameter int CAL_CYC    = 272800,
  parameter int BLANK_CYC  = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic recal_req,
  output logic adc_rst,
  output logic adc_cal,
  output logic adc_pd_n,
  output logic clk_en,
  output logic data_valid,
  output logic busy
);
  localparam int MAX_A = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC;
  localparam int MAX_B = (PULSE_CYC > BLANK_CYC) ? PULSE_CYC : BLANK_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] L_SET = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] L_PUL = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] L_CAL = CW'(CAL_CYC - 1);
  localparam logic [CW-1:0] L_BLK = CW'(BLANK_CYC - 1);

  typedef enum logic [2:0] {
    S_OFF, S_SETTLE, S_RST, S_CALP, S_CALW, S_BLANK, S_READY
  } seq_t;

  seq_t          st;
  logic [CW-1:0] cnt, lim;
  logic          pend;
  logic          done;

  always_comb begin
    case (st)
      S_SETTLE:      lim = L_SET;
      S_RST, S_CALP: lim = L_PUL;
      S_CALW:        lim = L_CAL;
      S_BLANK:       lim = L_BLK;
      default:       lim = '0;
    endcase
  end

  assign done = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_on) begin
      st   <= S_OFF;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= done ? '0 : cnt + 1'b1;
      if (recal_req && busy) pend <= 1'b1;
      case (st)
        S_OFF:    st <= S_SETTLE;
        S_SETTLE: if (done) st <= S_RST;
        S_RST:    if (done) st <= S_CALP;
        S_CALP:   if (done) st <= S_CALW;
        S_CALW:   if (done) st <= S_BLANK;
        S_BLANK:  if (done) st <= S_READY;
        S_READY:
          if (recal_req || pend) begin
            st   <= S_RST;
            pend <= 1'b0;
          end
        default:  st <= S_OFF;
      endcase
    end
  end

  assign adc_rst    = (st == S_RST);
  assign adc_cal    = (st == S_CALP);
  assign adc_pd_n   = (st != S_OFF);
  assign clk_en     = (st != S_OFF);
  assign data_valid = (st == S_READY);
  assign busy       = (st != S_OFF) && (st != S_READY);
endmodule

// File: rtl/conv_cal_sequencer_chk.sv
module conv_cal_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_on,
  input logic adc_rst,
  input logic adc_cal,
  input logic adc_pd_n,
  input logic clk_en,
  input logic data_valid,
  input logic busy
);
  // R3
  rst_cal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_rst && adc_cal));

  // R3
  cal_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cal) |-> $past(adc_rst));

  // R3
  rst_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_rst) && pwr_on) |=> adc_rst);

  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (!busy && adc_pd_n && !adc_rst && !adc_cal));

  // R8
  pd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!adc_pd_n && !data_valid && !busy));

  // R9
  clk_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || data_valid) |-> clk_en);
endmodule

bind conv_cal_sequencer conv_cal_sequencer_chk chk_i (.*);

// File: tb/tb_conv_cal_sequencer.sv
module tb_conv_cal_sequencer;
  localparam int S = 7, P = 3, C = 40, B = 13;

  logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, recal_req = 1'b0;
  logic adc_rst, adc_cal, adc_pd_n, clk_en, data_valid, busy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  conv_cal_sequencer #(.PULSE_CYC(P), .SETTLE_CYC(S), .CAL_CYC(C), .BLANK_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .recal_req(recal_req),
    .adc_rst(adc_rst), .adc_cal(adc_cal), .adc_pd_n(adc_pd_n),
    .clk_en(clk_en), .data_valid(data_valid), .busy(busy));

  // {rst, cal, valid, busy, pd_n, clk_en}
  localparam logic [5:0] V_OFF = 6'b000000, V_SET = 6'b000111, V_RST = 6'b100111,
                         V_CAL = 6'b010111, V_WAIT = 6'b000111, V_RDY = 6'b001011;

  function automatic logic [5:0] exp_vec(int j);
    if (j < S) return V_SET;
    if (j < S + P) return V_RST;
    if (j < S + 2*P) return V_CAL;
    if (j < S + 2*P + C + B) return V_WAIT;
    return V_RDY;
  endfunction

  function automatic string exp_tag(int j);
    if (j < S) return "R2";
    if (j < S + 2*P) return "R3";
    if (j < S + 2*P + C + B) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    logic [5:0] got = {adc_rst, adc_cal, data_valid, busy, adc_pd_n, clk_en};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic run_seq(input bit from_settle, input int inj, input int abort_at,
                         input string first_tag, output bit aborted);
    int total = (from_settle ? S : 0) + 2*P + C + B;
    aborted = 1'b0;
    for (int k = 0; k <= total; k++) begin
      int j = from_settle ? k : k + S;
      check((k == 0 && first_tag != "") ? first_tag : exp_tag(j), exp_vec(j));
      if (k == abort_at) begin
        recal_req = 1'b0;
        pwr_on = 1'b0;
        aborted = 1'b1;
        @(negedge clk);
        return;
      end
      recal_req = (k == inj && k < total);
      if (k < total) @(negedge clk);
    end
    recal_req = 1'b0;
  endtask

  initial begin
    #(100000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ab;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", V_OFF);
    pwr_on = 1'b1;
    @(negedge clk);
    check("R1", V_OFF);
    rst_n = 1'b1;
    pwr_on = 1'b0;
    @(negedge clk);
    check("R1", V_OFF);
    recal_req = 1'b1;
    @(negedge clk);
    recal_req = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R8", V_OFF);
    end

    pwr_on = 1'b1;
    @(negedge clk);
    run_seq(1'b1, -1, -1, "", ab);
    repeat (3) begin
      @(negedge clk);
      check("R9", V_RDY);
    end

    recal_req = 1'b1;
    @(negedge clk);
    recal_req = 1'b0;
    run_seq(1'b0, -1, -1, "R6", ab);

    for (int it = 0; it < 4; it++) begin
      int inj = $urandom_range(2*P + C + B - 1, 0);
      recal_req = 1'b1;
      @(negedge clk);
      recal_req = 1'b0;
      run_seq(1'b0, inj, -1, "R6", ab);
      @(negedge clk);
      check("R7", V_RST);
      run_seq(1'b0, -1, -1, "R7", ab);
    end

    for (int it = 0; it < 3; it++) begin
      int ab_at = $urandom_range(2*P + C + B, 1);
      int inj = $urandom_range(ab_at - 1, 0);
      recal_req = 1'b1;
      @(negedge clk);
      recal_req = 1'b0;
      run_seq(1'b0, inj, ab_at, "R6", ab);
      check("R8", V_OFF);
      @(negedge clk);
      check("R8", V_OFF);
      pwr_on = 1'b1;
      @(negedge clk);
      run_seq(1'b1, -1, -1, "R2", ab);
      repeat (3) begin
        @(negedge clk);
        check("R8", V_RDY);
      end
    end

    pwr_on = 1'b0;
    @(negedge clk);
    check("R8", V_OFF);
    pwr_on = 1'b1;
    @(negedge clk);
    ab = 1'b0;
    run_seq(1'b1, $urandom_range(S - 1, 0), -1, "R2", ab);
    @(negedge clk);
    check("R7", V_RST);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule